// File: doc/BRIEF.md
# Discrete Sense SPI Register Slave

This block is the serial front end of a 32-channel discrete-input threshold sensor. An external host talks to it over a four-wire SPI link in mode 0, where the clock idles low, data is sampled on the rising edge and driven on the falling edge. The block holds the configuration registers: a control byte, a per-bank sense-mode byte and two 16-bit threshold/hysteresis words. It drives these as parallel outputs to the comparator bank. It also returns the comparator outputs to the host, either one bank of eight channels at a time or all 32 channels at once.

Every transfer begins when chip select falls, and the first byte is the command. Its top bit is the direction flag and its low seven bits are the register address. For a write, one or two data bytes follow, most significant byte first, and the register is updated only once its last byte has arrived. For a read, the block samples the register value when the command byte ends. It then shifts that value out most significant bit first for as long as chip select stays low, and sends zeros once the register's bytes are used up.

The SPI pins are synchronised into the system clock domain and their edges are detected there, so the serial clock must run well below the system clock.

Top module: `sense_spi_slave`

## Requirements
- R1: The command byte is the first byte after chip select falls. Bit 7 = 1 selects a read and bit 7 = 0 selects a write. Bits 6..0 carry the register address. At most one read-capture or write-commit strobe occurs in any cycle.
- R2: Bits move most significant first in both directions. MOSI is sampled on the rising edge of the serial clock. MISO changes after a falling edge, so the first bit of read data is valid before the first rising edge of the byte that follows the command.
- R3: A read of address 0x78 returns all sense inputs as a four-byte word. The first bit out is channel 31, and the fourth byte ends with channel 0.
- R4: A read of address 0x10, 0x12, 0x14 or 0x16 returns one byte holding channels 7..0, 15..8, 23..16 or 31..24 respectively, with the highest channel in bit 7.
- R5: The read value is captured when the command byte ends. Sense input changes after that point do not alter the bytes already being returned.
- R6: The ground-open threshold word is at 0x3A and the supply-open word is at 0x3C. Each is 16 bits, is written as two bytes with the high byte first, reads back as two bytes, and resets to 0x0206.
- R7: The sense-mode register is at 0x04. Bits 3..0 select the mode of the four 8-channel banks and drive the mode output. Bits 7..4 read as 0. The register resets to 0x00.
- R8: The control register is at 0x02. Bit 0 is test mode and bit 1 is soft reset. While bit 1 is 1, the mode register and both threshold words are held at their reset values and writes to them are ignored. Writing bit 1 high and then low therefore returns them to reset. Control reads back bits 1..0 with the upper bits 0.
- R9: When chip select rises, the transfer in progress is abandoned. A write whose final data byte has not fully arrived changes nothing.
- R10: An address with no register reads as 0x00 and ignores writes. Bytes read beyond a register's length are 0x00, and data bytes written beyond a register's length are ignored.
- R11: MISO is 0 while chip select is high and throughout the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | Serial clock from the host |
| spi_cs_n_i | input | 1 | Chip select, active low |
| spi_mosi_i | input | 1 | Host-to-slave serial data |
| spi_miso_o | output | 1 | Slave-to-host serial data |
| sense_i | input | SENSE_W | Comparator outputs, one bit per channel |
| soft_rst_o | output | 1 | Control bit 1 (soft reset) |
| test_mode_o | output | 1 | Control bit 0 (test mode) |
| mode_sel_o | output | SENSE_W/8 | Per-bank sense mode select |
| thr_gnd_o | output | 16 | Ground-open threshold word |
| thr_sup_o | output | 16 | Supply-open threshold word |

## Verification
The bench builds the block with its default parameters: 32 sense channels in four banks, a two-stage pin synchroniser and a 16-bit threshold reset value of 0x0206. The serial clock runs at one twentieth of the system clock. With these values every bank byte address is reachable, along with the full four-byte word read and both threshold words. Bytes read past the end of a four-byte word can also be checked. The slow serial clock leaves enough room to change the sense inputs between the command byte and the data bytes, and to drop chip select partway through a two-byte write.

// File: rtl/sense_spi_pkg.sv
package sense_spi_pkg;

    // Register addresses (seven-bit field of the command byte)
    localparam logic [6:0] A_CTRL    = 7'h02;
    localparam logic [6:0] A_MODE    = 7'h04;
    localparam logic [6:0] A_BANK0   = 7'h10;
    localparam logic [6:0] A_THR_GND = 7'h3A;
    localparam logic [6:0] A_THR_SUP = 7'h3C;
    localparam logic [6:0] A_WORD    = 7'h78;

    localparam int BYTE_W = 8;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    // Number of data bytes a write to this address needs before it commits;
    // zero marks an address that cannot be written.
    function automatic logic [1:0] wr_len(input logic [6:0] a);
        case (a)
            A_CTRL, A_MODE:       return 2'd1;
            A_THR_GND, A_THR_SUP: return 2'd2;
            default:              return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic mosi_s
);
    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sclk;
        logic [SYNC_STAGES-1:0] cs_n;
        logic [SYNC_STAGES-1:0] mosi;
        logic                   sclk_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d           = sync_q;
        sync_d.sclk      = {sync_q.sclk[TOP-1:0], sclk_i};
        sync_d.cs_n      = {sync_q.cs_n[TOP-1:0], cs_n_i};
        sync_d.mosi      = {sync_q.mosi[TOP-1:0], mosi_i};
        sync_d.sclk_prev = sync_q.sclk[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.sclk      <= '0;
            sync_q.cs_n      <= '1;
            sync_q.mosi      <= '0;
            sync_q.sclk_prev <= 1'b0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sclk_rise = sync_q.sclk[TOP] & ~sync_q.sclk_prev;
    assign sclk_fall = ~sync_q.sclk[TOP] & sync_q.sclk_prev;
    assign cs_act    = ~sync_q.cs_n[TOP];
    assign mosi_s    = sync_q.mosi[TOP];

endmodule

// File: rtl/spi_byte_framer.sv
module spi_byte_framer
    import sense_spi_pkg::*;
#(
    parameter int SENSE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               cs_act,
    input  logic               mosi_s,
    input  logic [SENSE_W-1:0] rd_word,
    output logic               rd_load,
    output logic [6:0]         rd_addr,
    output logic               wr_commit,
    output logic [6:0]         wr_addr,
    output logic [15:0]        wr_data,
    output logic               miso
);
    typedef struct packed {
        phase_e             phase;
        logic [2:0]         bit_cnt;
        logic [7:0]         shreg;
        logic               is_read;
        logic [6:0]         addr;
        logic [1:0]         n_rx;
        logic [15:0]        wbuf;
        logic [SENSE_W-1:0] rd;
        logic               miso;
    } frm_t;

    localparam frm_t FRM_IDLE = '{
        phase:   PH_CMD,
        bit_cnt: 3'd0,
        shreg:   8'd0,
        is_read: 1'b0,
        addr:    7'd0,
        n_rx:    2'd0,
        wbuf:    16'd0,
        rd:      '0,
        miso:    1'b0
    };

    frm_t frm_d, frm_q;
    logic [7:0] byte_v;
    logic [1:0] need;

    always_comb begin
        frm_d     = frm_q;
        rd_load   = 1'b0;
        wr_commit = 1'b0;
        byte_v    = {frm_q.shreg[6:0], mosi_s};
        rd_addr   = byte_v[6:0];
        wr_addr   = frm_q.addr;
        wr_data   = {frm_q.wbuf[7:0], byte_v};
        need      = wr_len(frm_q.addr);

        if (!cs_act) begin
            frm_d = FRM_IDLE;
        end else begin
            if (sclk_rise) begin
                frm_d.shreg   = byte_v;
                frm_d.bit_cnt = 3'(frm_q.bit_cnt + 3'd1);
                if (frm_q.bit_cnt == 3'd7) begin
                    if (frm_q.phase == PH_CMD) begin
                        frm_d.phase   = PH_DATA;
                        frm_d.is_read = byte_v[7];
                        frm_d.addr    = byte_v[6:0];
                        frm_d.n_rx    = 2'd0;
                        if (byte_v[7]) begin
                            rd_load  = 1'b1;
                            frm_d.rd = rd_word;
                        end
                    end else if (!frm_q.is_read) begin
                        frm_d.wbuf = wr_data;
                        if (frm_q.n_rx != 2'd3) begin
                            frm_d.n_rx = 2'(frm_q.n_rx + 2'd1);
                        end
                        if (need != 2'd0 && 2'(frm_q.n_rx + 2'd1) == need) begin
                            wr_commit = 1'b1;
                        end
                    end
                end
            end
            if (sclk_fall) begin
                frm_d.miso = frm_q.rd[SENSE_W-1];
                frm_d.rd   = frm_q.rd << 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= FRM_IDLE;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign miso = frm_q.miso;

    // R5: sampling edges in the data phase never disturb the captured read value
    a_r5_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && cs_act && frm_q.phase == PH_DATA) |=> $stable(frm_q.rd));

endmodule

// File: rtl/sense_regfile.sv
module sense_regfile
    import sense_spi_pkg::*;
#(
    parameter int          SENSE_W   = 32,
    parameter logic [15:0] THR_RESET = 16'h0206
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [6:0]         wr_addr,
    input  logic [15:0]        wr_data,
    input  logic [6:0]         rd_addr,
    input  logic [SENSE_W-1:0] sense_i,
    output logic [SENSE_W-1:0] rd_word,
    output logic [1:0]         ctrl_o,
    output logic [SENSE_W/8-1:0] mode_o,
    output logic [15:0]        thr_gnd_o,
    output logic [15:0]        thr_sup_o
);
    localparam int BANKS = SENSE_W / BYTE_W;

    typedef struct packed {
        logic [1:0]       ctrl;
        logic [BANKS-1:0] mode;
        logic [15:0]      thr_gnd;
        logic [15:0]      thr_sup;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  srst_q;
    logic [7:0] mode_byte;

    assign srst_q = regs_q.ctrl[1];

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL:    regs_d.ctrl = wr_data[1:0];
                A_MODE:    if (!srst_q) regs_d.mode = wr_data[BANKS-1:0];
                A_THR_GND: if (!srst_q) regs_d.thr_gnd = wr_data;
                A_THR_SUP: if (!srst_q) regs_d.thr_sup = wr_data;
                default:   ;
            endcase
        end
        if (srst_q) begin
            regs_d.mode    = '0;
            regs_d.thr_gnd = THR_RESET;
            regs_d.thr_sup = THR_RESET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.ctrl    <= 2'b00;
            regs_q.mode    <= '0;
            regs_q.thr_gnd <= THR_RESET;
            regs_q.thr_sup <= THR_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Read value, left-aligned so the first byte out is the top byte
    always_comb begin
        mode_byte                = '0;
        mode_byte[BANKS-1:0]     = regs_q.mode;
        rd_word                  = '0;
        case (rd_addr)
            A_CTRL:    rd_word[SENSE_W-1 -: 8]  = {6'd0, regs_q.ctrl};
            A_MODE:    rd_word[SENSE_W-1 -: 8]  = mode_byte;
            A_THR_GND: rd_word[SENSE_W-1 -: 16] = regs_q.thr_gnd;
            A_THR_SUP: rd_word[SENSE_W-1 -: 16] = regs_q.thr_sup;
            A_WORD:    rd_word                  = sense_i;
            default:   ;
        endcase
        for (int k = 0; k < BANKS; k++) begin
            if (rd_addr == 7'(A_BANK0 + 7'(2 * k))) begin
                rd_word                 = '0;
                rd_word[SENSE_W-1 -: 8] = sense_i[8*k +: 8];
            end
        end
    end

    assign ctrl_o    = regs_q.ctrl;
    assign mode_o    = regs_q.mode;
    assign thr_gnd_o = regs_q.thr_gnd;
    assign thr_sup_o = regs_q.thr_sup;

    // R8: a held soft reset keeps the configuration at reset values
    a_r8_soft_reset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ctrl[1] && $past(regs_q.ctrl[1])) |->
        (regs_q.thr_gnd == THR_RESET && regs_q.thr_sup == THR_RESET && regs_q.mode == '0));

    // R6: a committed threshold write lands unchanged
    a_r6_thr_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_THR_GND && !regs_q.ctrl[1]) |=> (regs_q.thr_gnd == $past(wr_data)));

    // R10: a write to an unmapped address changes no register
    a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_len(wr_addr) == 2'd0) |=> $stable(regs_q));

endmodule

// File: rtl/sense_spi_slave.sv
module sense_spi_slave
    import sense_spi_pkg::*;
#(
    parameter int          SENSE_W     = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] THR_RESET   = 16'h0206
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_sclk_i,
    input  logic                 spi_cs_n_i,
    input  logic                 spi_mosi_i,
    output logic                 spi_miso_o,
    input  logic [SENSE_W-1:0]   sense_i,
    output logic                 soft_rst_o,
    output logic                 test_mode_o,
    output logic [SENSE_W/8-1:0] mode_sel_o,
    output logic [15:0]          thr_gnd_o,
    output logic [15:0]          thr_sup_o
);
    logic               sclk_rise, sclk_fall, cs_act, mosi_s;
    logic               rd_load, wr_commit;
    logic [6:0]         rd_addr, wr_addr;
    logic [15:0]        wr_data;
    logic [SENSE_W-1:0] rd_word;
    logic [1:0]         ctrl;

    spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (spi_sclk_i),
        .cs_n_i    (spi_cs_n_i),
        .mosi_i    (spi_mosi_i),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .mosi_s    (mosi_s)
    );

    spi_byte_framer #(.SENSE_W(SENSE_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .mosi_s    (mosi_s),
        .rd_word   (rd_word),
        .rd_load   (rd_load),
        .rd_addr   (rd_addr),
        .wr_commit (wr_commit),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .miso      (spi_miso_o)
    );

    sense_regfile #(.SENSE_W(SENSE_W), .THR_RESET(THR_RESET)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_commit),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .sense_i   (sense_i),
        .rd_word   (rd_word),
        .ctrl_o    (ctrl),
        .mode_o    (mode_sel_o),
        .thr_gnd_o (thr_gnd_o),
        .thr_sup_o (thr_sup_o)
    );

    assign soft_rst_o  = ctrl[1];
    assign test_mode_o = ctrl[0];

    // R11: MISO stays low while chip select has been idle
    a_r11_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && !$past(cs_act)) |-> !spi_miso_o);

    // R1: a command is either a read capture or a write commit, never both at once
    a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_load, wr_commit}));

    // R9: nothing commits once chip select is released
    a_r9_no_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> cs_act);

endmodule

// File: tb/sense_spi_slave_tb.sv
module sense_spi_slave_tb;
    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [31:0] sense = 32'h0;
    logic        soft_rst, test_mode;
    logic [3:0]  mode_sel;
    logic [15:0] thr_gnd, thr_sup;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sense_spi_slave u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sclk_i  (sclk),
        .spi_cs_n_i  (cs_n),
        .spi_mosi_i  (mosi),
        .spi_miso_o  (miso),
        .sense_i     (sense),
        .soft_rst_o  (soft_rst),
        .test_mode_o (test_mode),
        .mode_sel_o  (mode_sel),
        .thr_gnd_o   (thr_gnd),
        .thr_sup_o   (thr_sup)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hw();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_start();
        cs_n = 1'b0;
        hw();
    endtask

    task automatic cs_end();
        hw();
        cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            hw();
            rx[i] = miso;
            sclk = 1'b1;
            hw();
            sclk = 1'b0;
        end
    endtask

    task automatic wr1(input logic [6:0] a, input logic [7:0] v);
        logic [7:0] r;
        cs_start();
        xbyte({1'b0, a}, r);
        xbyte(v, r);
        cs_end();
    endtask

    task automatic wr2(input logic [6:0] a, input logic [15:0] v);
        logic [7:0] r;
        cs_start();
        xbyte({1'b0, a}, r);
        xbyte(v[15:8], r);
        xbyte(v[7:0], r);
        cs_end();
    endtask

    // Reads n bytes, returns them packed low-aligned; cmd_rx is MISO during the command
    task automatic rd(input logic [6:0] a, input int n, output logic [39:0] v, output logic [7:0] cmd_rx);
        logic [7:0] r;
        v = '0;
        cs_start();
        xbyte({1'b1, a}, cmd_rx);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r);
            v = {v[31:0], r};
        end
        cs_end();
    endtask

    task automatic t_reset();
        check("R6 gnd threshold reset", 32'(thr_gnd), 32'h0206);
        check("R6 supply threshold reset", 32'(thr_sup), 32'h0206);
        check("R7 mode reset", 32'(mode_sel), 32'h0);
        check("R8 control reset", {30'd0, soft_rst, test_mode}, 32'h0);
        check("R11 miso idle", 32'(miso), 32'h0);
    endtask

    task automatic t_word_read();
        logic [39:0] v;
        logic [7:0]  c;
        sense = 32'h8123_45E7;
        rd(7'h78, 5, v, c);
        check("R3 R2 four-byte word, channel 31 first", v[39:8], 32'h8123_45E7);
        check("R10 byte past word is zero", 32'(v[7:0]), 32'h0);
        check("R11 miso low during command", 32'(c), 32'h0);
        check("R11 miso low after release", 32'(miso), 32'h0);
    endtask

    task automatic t_bank_read();
        logic [39:0] v;
        logic [7:0]  c;
        sense = 32'hA55A_3CC3;
        for (int k = 0; k < 4; k++) begin
            rd(7'(7'h10 + 2 * k), 1, v, c);
            check("R4 bank byte", 32'(v[7:0]), 32'((sense >> (8 * k)) & 32'hFF));
        end
    endtask

    task automatic t_snapshot();
        logic [7:0]  r, c;
        logic [31:0] v;
        sense = 32'h1357_9BDF;
        cs_start();
        xbyte(8'hF8, c);
        sense = 32'hFFFF_0000;
        v = '0;
        for (int i = 0; i < 4; i++) begin
            xbyte(8'h00, r);
            v = {v[23:0], r};
        end
        cs_end();
        check("R5 read captured at command end", v, 32'h1357_9BDF);
    endtask

    task automatic t_threshold();
        logic [39:0] v;
        logic [7:0]  c;
        wr2(7'h3A, 16'h040A);
        check("R6 gnd threshold write", 32'(thr_gnd), 32'h040A);
        wr2(7'h3C, 16'h0812);
        check("R6 supply threshold write", 32'(thr_sup), 32'h0812);
        rd(7'h3A, 3, v, c);
        check("R6 gnd threshold readback", 32'(v[23:8]), 32'h040A);
        check("R10 byte past threshold is zero", 32'(v[7:0]), 32'h0);
        rd(7'h3C, 2, v, c);
        check("R6 supply threshold readback", 32'(v[15:0]), 32'h0812);
    endtask

    task automatic t_mode();
        logic [39:0] v;
        logic [7:0]  c, r;
        wr1(7'h04, 8'hFA);
        check("R7 mode write", 32'(mode_sel), 32'hA);
        rd(7'h04, 1, v, c);
        check("R7 mode readback upper zero", 32'(v[7:0]), 32'h0A);
        // extra data byte after a one-byte register is ignored
        cs_start();
        xbyte(8'h04, r);
        xbyte(8'h05, r);
        xbyte(8'h0F, r);
        cs_end();
        check("R10 extra write byte ignored", 32'(mode_sel), 32'h5);
    endtask

    task automatic t_partial();
        logic [7:0] r;
        cs_start();
        xbyte(8'h3C, r);
        xbyte(8'h11, r);
        cs_end();
        check("R9 partial two-byte write", 32'(thr_sup), 32'h0812);
        cs_start();
        xbyte(8'h04, r);
        cs_end();
        check("R9 write with no data", 32'(mode_sel), 32'h5);
        cs_start();
        xbyte(8'h04, r);
        for (int i = 7; i >= 4; i--) begin
            mosi = 1'b1;
            hw();
            sclk = 1'b1;
            hw();
            sclk = 1'b0;
        end
        cs_end();
        check("R9 mid-byte abort", 32'(mode_sel), 32'h5);
        wr1(7'h04, 8'h03);
        check("R1 next transfer after abort", 32'(mode_sel), 32'h3);
    endtask

    task automatic t_unmapped();
        logic [39:0] v;
        logic [7:0]  c;
        wr1(7'h20, 8'h55);
        wr2(7'h3B, 16'hFFFF);
        check("R10 unmapped write leaves mode", 32'(mode_sel), 32'h3);
        check("R10 unmapped write leaves thresholds", {thr_gnd, thr_sup}, 32'h040A_0812);
        rd(7'h20, 4, v, c);
        check("R10 unmapped read zero", v[31:0], 32'h0);
    endtask

    task automatic t_soft_reset();
        logic [39:0] v;
        logic [7:0]  c;
        wr1(7'h02, 8'h02);
        check("R8 soft reset output", 32'(soft_rst), 32'h1);
        check("R8 gnd threshold forced", 32'(thr_gnd), 32'h0206);
        check("R8 mode forced", 32'(mode_sel), 32'h0);
        wr2(7'h3C, 16'h0A0C);
        check("R8 write ignored in soft reset", 32'(thr_sup), 32'h0206);
        wr1(7'h02, 8'h00);
        check("R8 released, values stay reset", {thr_gnd, thr_sup}, 32'h0206_0206);
        check("R8 soft reset cleared", 32'(soft_rst), 32'h0);
        wr1(7'h02, 8'hFD);
        check("R8 test mode output", 32'(test_mode), 32'h1);
        rd(7'h02, 1, v, c);
        check("R8 control readback", 32'(v[7:0]), 32'h01);
        wr2(7'h3A, 16'h0610);
        check("R8 writes accepted after release", 32'(thr_gnd), 32'h0610);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_word_read();
        t_bank_read();
        t_snapshot();
        t_threshold();
        t_mode();
        t_partial();
        t_unmapped();
        t_soft_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule